// File: doc/BRIEF.md
# Buffered Multi-Channel PWM Timer

This block produces several edge-aligned PWM waveforms from one shared up-counter. A small synchronous register port sets a clock mode that starts and stops the counter, a power-of-two prescale, the period (modulo) value, and for each channel a control field and a compare value. Every channel uses the counter's period and prescale. Each channel sets its own duty through its compare value and its own polarity through its control field.

When the counter is stopped, writes to the period or compare registers take effect at once. When it runs, they wait in a holding register and are moved into the active copy at the next wrap of the counter. This avoids a truncated or stretched period. A read always returns the active value, so software can poll until the readback equals what it wrote. Channel control writes skip this holding stage and change the output on the next cycle.

Register map, with word addresses and the data in the low bits: address 0 holds the clock mode in bits [1:0] and the prescale exponent in bits [4:2]. Address 1 holds the period. Channel k uses address 2+2k for its control field, with polarity select in bits [1:0] and mode select in bits [3:2], and address 3+2k for its compare value.

Top module: `pwm_timer`

## Requirements
- R1: After reset, address 0 reads 0, the period reads all ones, every channel control and compare value reads 0, and every PWM output is low.
- R2: The counter advances only while the clock mode (address 0 bits [1:0]) is non-zero. Any non-zero value starts it. While the mode is 0 the counter sits at 0.
- R3: The counter steps once every 2^P clock cycles, where P is address 0 bits [4:2]. It counts 0..M for period value M and then wraps to 0, so one PWM period lasts (M+1)*2^P cycles.
- R4: With the counter stopped, a period write is visible on readback in the next cycle.
- R5: With the counter running, a period write leaves the readback and the active period unchanged until the next counter wrap, where the new value takes over. A value still held when the counter is stopped is applied at once.
- R6: Compare-value writes follow the same rule: immediate when stopped, held until the next wrap while running.
- R7: A channel with normal polarity is high for min(C, M+1) counts of each period, for compare value C. A compare value of 0 gives a constant low, and one above M gives a constant high.
- R8: Polarity select 01 inverts the channel output. The values 10, 00 and 11 give normal polarity whenever the channel is enabled. Mode select 01 with polarity select 00 enables a normal channel.
- R9: A channel whose four control bits are all 0 is disabled and drives a constant low.
- R10: A change of channel control alters the output in the cycle after the write, even with the counter stopped.
- R11: All channels share one counter, so channels with different compare values show the same period.
- R12: Writes to addresses beyond 2+2*N-1 change no register, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW ($clog2(2*NCH+2)) | Register word address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for reg_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The hardest case to reach from the ports is a period or compare write that lands while the counter runs, far enough from a wrap that the held value can be seen before it is applied. The counter cannot be read, so the stimulus infers its position from a channel with a small compare value: the falling edge of that channel marks a known count. The writes are issued right after that edge, and the readback is checked both before and after the coming wrap. A second case writes a held value and then stops the counter before the wrap, to confirm the value is applied on stop.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CMODE_W   = 2;
  localparam int CH_BASE   = 2;
  localparam int CTRL_ADDR = 0;
  localparam int MOD_ADDR  = 1;
  localparam logic [1:0] POL_INVERT = 2'b01;

  typedef struct packed {
    logic [1:0] msel;
    logic [1:0] pol;
  } chan_ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] ps,
  output logic           tick
);
  localparam int DIVW = (1 << PSW) - 1;

  logic [DIVW-1:0] div_q, div_d, lim;

  always_comb begin
    lim  = ~({DIVW{1'b1}} << ps);
    tick = run && (div_q >= lim);
    if (!run || div_q >= lim) div_d = '0;
    else                      div_d = div_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         boundary,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] act
);
  logic [W-1:0] act_q, act_d, hold_q, hold_d;
  logic         pend_q, pend_d;
  logic         act_en, hold_en;

  always_comb begin
    act_d   = act_q;
    hold_d  = hold_q;
    pend_d  = pend_q;
    if (!run) begin
      if (we) begin
        act_d  = wdata;
        pend_d = 1'b0;
      end else if (pend_q) begin
        act_d  = hold_q;
        pend_d = 1'b0;
      end
    end else begin
      if (boundary && pend_q) begin
        act_d  = hold_q;
        pend_d = 1'b0;
      end
      if (we) begin
        hold_d = wdata;
        pend_d = 1'b1;
      end
    end
    act_en  = (act_d != act_q);
    hold_en = run && we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= RST_VAL;
      hold_q <= RST_VAL;
      pend_q <= 1'b0;
    end else begin
      if (act_en)  act_q  <= act_d;
      if (hold_en) hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign act = act_q;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          mod_we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] mod_act,
  output logic          wrap
);
  logic [CW-1:0] cnt_q, cnt_d;

  pwm_shadow_reg #(.W(CW), .RST_VAL({CW{1'b1}})) u_mod (
    .clk(clk), .rst_n(rst_n), .run(run), .boundary(wrap),
    .we(mod_we), .wdata(wdata), .act(mod_act)
  );

  always_comb begin
    wrap  = run && tick && (cnt_q >= mod_act);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic          ctrl_we,
  input  logic          cv_we,
  input  logic [CW-1:0] wdata,
  output chan_ctrl_t    ctrl,
  output logic [CW-1:0] cv_act,
  output logic          pwm
);
  chan_ctrl_t ctrl_q;
  logic       enabled, inv, raw;

  pwm_shadow_reg #(.W(CW), .RST_VAL('0)) u_cv (
    .clk(clk), .rst_n(rst_n), .run(run), .boundary(wrap),
    .we(cv_we), .wdata(wdata), .act(cv_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= chan_ctrl_t'(wdata[3:0]);
  end

  always_comb begin
    enabled = (ctrl_q != '0);
    inv     = (ctrl_q.pol == POL_INVERT);
    raw     = (cnt < cv_act);
    pwm     = enabled && (raw ^ inv);
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int CW  = 16,
  parameter  int PSW = 3,
  localparam int AW  = $clog2(2 * NCH + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  reg_addr,
  input  logic           reg_we,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int CTRL_W = CMODE_W + PSW;

  logic [1:0]          rst_sync;
  logic                rst_sn;
  logic [CMODE_W-1:0]  cmode_q;
  logic [PSW-1:0]      ps_q;
  logic                ctrl_we, mod_we, run, tick, wrap;
  logic [CW-1:0]       cnt, mod_act;
  logic [NCH-1:0]      ch_ctrl_we, ch_cv_we;
  chan_ctrl_t          ctrl_arr [NCH];
  logic [CW-1:0]       cv_arr   [NCH];
  logic [4*NCH-1:0]    ch_ctrl_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  assign ctrl_we = reg_we && (reg_addr == AW'(CTRL_ADDR));
  assign mod_we  = reg_we && (reg_addr == AW'(MOD_ADDR));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmode_q <= '0;
      ps_q    <= '0;
    end else if (ctrl_we) begin
      cmode_q <= reg_wdata[CMODE_W-1:0];
      ps_q    <= reg_wdata[CTRL_W-1:CMODE_W];
    end
  end

  assign run = (cmode_q != '0);

  pwm_prescaler #(.PSW(PSW)) u_pre (
    .clk(clk), .rst_n(rst_sn), .run(run), .ps(ps_q), .tick(tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_sn), .run(run), .tick(tick),
    .mod_we(mod_we), .wdata(reg_wdata),
    .cnt(cnt), .mod_act(mod_act), .wrap(wrap)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_ctrl_we[k] = reg_we && (reg_addr == AW'(CH_BASE + 2 * k));
    assign ch_cv_we[k]   = reg_we && (reg_addr == AW'(CH_BASE + 2 * k + 1));

    pwm_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_sn), .run(run), .wrap(wrap), .cnt(cnt),
      .ctrl_we(ch_ctrl_we[k]), .cv_we(ch_cv_we[k]), .wdata(reg_wdata),
      .ctrl(ctrl_arr[k]), .cv_act(cv_arr[k]), .pwm(pwm_out[k])
    );

    assign ch_ctrl_flat[4*k +: 4] = ctrl_arr[k];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(CTRL_ADDR)) reg_rdata = CW'({ps_q, cmode_q});
    if (reg_addr == AW'(MOD_ADDR))  reg_rdata = mod_act;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == AW'(CH_BASE + 2 * k))     reg_rdata = CW'(ctrl_arr[k]);
      if (reg_addr == AW'(CH_BASE + 2 * k + 1)) reg_rdata = cv_arr[k];
    end
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmode,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    mod_act,
  input logic             wrap,
  input logic [4*NCH-1:0] ch_ctrl,
  input logic [NCH-1:0]   pwm_out
);
  assert_stopped_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode == 2'b00) |=> (cnt == '0));

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= mod_act);

  assert_wrap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_period_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmode != 2'b00 && !wrap) |=> $stable(mod_act));

  for (genvar k = 0; k < NCH; k++) begin : g_off
    assert_disabled_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ctrl[4*k +: 4] == 4'b0000) |-> !pwm_out[k]);
  end
endmodule

bind pwm_timer pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .cmode(cmode_q), .cnt(cnt), .mod_act(mod_act),
  .wrap(wrap), .ch_ctrl(ch_ctrl_flat), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_test.sv
module pwm_timer_test;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic           reg_we = 1'b0;
  logic [CW-1:0]  reg_wdata = '0;
  logic [CW-1:0]  reg_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;

  pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr  = AW'(a);
    reg_wdata = CW'(d);
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic measure(input int ch, input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (pwm_out[ch]) highs++;
    end
  endtask

  task automatic t_reset();
    int v;
    chk("R1 outputs low", int'(pwm_out), 0);
    rd(0, v); chk("R1 control", v, 0);
    rd(1, v); chk("R1 period", v, 16'hFFFF);
    for (int k = 0; k < NCH; k++) begin
      rd(2 + 2 * k, v); chk("R1 channel ctrl", v, 0);
      rd(3 + 2 * k, v); chk("R1 compare", v, 0);
    end
  endtask

  task automatic t_stopped();
    int v, h;
    wr(1, 9);  rd(1, v); chk("R4 period immediate", v, 9);
    wr(3, 3);  rd(3, v); chk("R6 compare immediate", v, 3);
    wr(2, 4'b0010);
    measure(0, 20, h); chk("R2 stopped counter holds", h, 20);
  endtask

  task automatic t_duty();
    int h;
    wr(4, 4'b0010); wr(5, 0);
    wr(6, 4'b0010); wr(7, 15);
    wr(8, 4'b0010); wr(9, 7);
    measure(1, 10, h); chk("R2 stopped cv0 low", h, 0);
    wr(0, 1);
    measure(0, 40, h); chk("R7 duty cv3", h, 12);
    measure(1, 40, h); chk("R7 cv0 zero duty", h, 0);
    measure(2, 40, h); chk("R7 cv above period full", h, 40);
    measure(3, 40, h); chk("R11 shared period cv7", h, 28);
    wr(0, 0);
  endtask

  task automatic t_prescale();
    int h;
    wr(1, 4); wr(3, 2);
    wr(0, 5'b01010);
    measure(0, 40, h); chk("R3 prescale by 4", h, 16);
    measure(2, 40, h); chk("R3 prescaled full duty", h, 40);
    wr(0, 0);
  endtask

  task automatic t_polarity();
    int h;
    wr(1, 9); wr(3, 3);
    wr(0, 1);
    wr(2, 4'b0001); measure(0, 40, h); chk("R8 inverted", h, 28);
    wr(2, 4'b0011); measure(0, 40, h); chk("R8 pol 11 normal", h, 12);
    wr(2, 4'b0100); measure(0, 40, h); chk("R8 msel only normal", h, 12);
    wr(2, 4'b0000); measure(0, 40, h); chk("R9 disabled low", h, 0);
    wr(0, 0);
    wr(2, 4'b0010); chk("R10 enable immediate", int'(pwm_out[0]), 1);
    wr(2, 4'b0001); chk("R10 invert immediate", int'(pwm_out[0]), 0);
    wr(2, 4'b0000); chk("R10 disable immediate", int'(pwm_out[0]), 0);
    wr(2, 4'b0010); chk("R10 re-enable immediate", int'(pwm_out[0]), 1);
  endtask

  task automatic t_buffered();
    int v, m, c, h, n;
    logic prev;
    wr(1, 19); wr(3, 2);
    wr(0, 1);
    prev = pwm_out[0];
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (prev && !pwm_out[0]) break;
      prev = pwm_out[0];
    end
    wr(3, 12);
    wr(1, 29);
    rd(3, v); chk("R6 compare held while running", v, 2);
    rd(1, v); chk("R5 period held while running", v, 19);
    repeat (6) @(negedge clk);
    rd(1, v); chk("R5 period still held", v, 19);
    n = 0;
    m = 0;
    for (int i = 0; i < 40; i++) begin
      rd(1, m);
      if (m == 29) break;
      n++;
    end
    chk("R5 period applied at wrap", m, 29);
    chk("R5 applied within one period", int'(n < 20), 1);
    rd(3, c); chk("R6 compare applied at wrap", c, 12);
    measure(0, 60, h); chk("R6 new duty after wrap", h, 24);
  endtask

  task automatic t_stop_pending();
    int v;
    wr(1, 9);
    wr(3, 5);
    wr(0, 0);
    rd(1, v); chk("R5 held period applied on stop", v, 9);
    rd(3, v); chk("R6 held compare applied on stop", v, 5);
  endtask

  task automatic t_unmapped();
    int v;
    wr(12, 16'hFFFF);
    wr(15, 16'h00FF);
    rd(12, v); chk("R12 unmapped read zero", v, 0);
    rd(0, v);  chk("R12 control untouched", v, 0);
    rd(1, v);  chk("R12 period untouched", v, 9);
    rd(2, v);  chk("R12 ctrl untouched", v, 4'b0010);
    rd(3, v);  chk("R12 compare untouched", v, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_stopped();
    t_duty();
    t_prescale();
    t_polarity();
    t_buffered();
    t_stop_pending();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule